// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects nine level-sensitive interrupt inputs and presents them on three active-high request lines toward a host interrupt controller. Every input passes through a two-stage synchronizer. A polarity stage then turns it into an "active" flag. A source is active-high when its polarity bit is 1 and active-low when it is 0. Sources 1 and 8 are hardwired active-high and source 2 is hardwired active-low. The other six sources are programmable.

Each request line owns one 32-bit control word. Its low half holds one enable bit per source, and bits 16 upward hold one pending bit per source. A pending bit records that its source was active. Software clears it by writing a 1 to it. A source is routed to a line by setting its enable bit in that line's word. A line asserts while any of its pending bits is both set and enabled. Software drives the block over a simple synchronous register port with address, read and write strobes, and 32-bit data in each direction. Writing 0x01FF0000 to a line word clears that line: all enables off and all pending bits acknowledged.

Top module: `rlic_top`

## Requirements
- R1: After reset the polarity word reads 0x00000102, every line word reads 0, and `irq_out` is 0.
- R2: The polarity word sits at byte offset 0x0 and holds bit n = polarity of source n (1 = active-high, 0 = active-low). Writes to the programmable bits take effect at the next clock, and bits 31:9 read as 0.
- R3: Polarity bits 1 and 8 always read 1 and bit 2 always reads 0, whatever is written.
- R4: The word for line n is at byte offset 4+4n, decoded from `addr[3:2]`, with `addr[1:0]` ignored. A change of `irq_in` that makes a source active sets pending bit 16+s at the third rising edge after the change, in all three line words, whatever the enables are.
- R5: Writing 1 to bit 16+s of a line word clears that pending bit in that word only. If the source is still active, the bit is set again at the next edge. Writing 0 to a pending bit leaves it unchanged.
- R6: Bits 8:0 of a line word are enable bits that read back as written. Bits 31:25 and 15:9 of a line word read as 0.
- R7: `irq_out[n]` is 1 exactly when line n has a source whose pending and enable bits are both set. This holds for either polarity.
- R8: Read data is registered. `rdata` shows the addressed word one edge after the edge that samples `rd_en`, and is 0 after an edge with `rd_en` low.
- R9: Writing 0x01FF0000 to a line word leaves that word reading 0 and its request line low while the inputs are inactive.
- R10: The pending bits of the three lines are independent. Acknowledging a pending bit on one line does not clear it on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 9 | Raw interrupt source levels |
| addr | input | 4 | Byte address of the register word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 3 | Active-high request lines |

## Verification
A change on `irq_in` reaches the pending bits and `irq_out` at the third rising edge, after two synchronizer edges and the pending register. A register write changes state at the very next edge, and read data appears one edge after the read strobe. The reference model in the bench copies these delays with a short queue for the synchronizer. It compares `irq_out` and `rdata` at every falling edge, so each result is checked in the cycle it becomes due. Directed checks sample `irq_out` one nanosecond after each of the first three edges following an input change, to show the bit is low for two edges and high on the third.

// File: rtl/rlic_pkg.sv
package rlic_pkg;
    localparam int NUM_SRC     = 9;
    localparam int NUM_LINES   = 3;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int PEND_LSB    = 16;
    localparam int SYNC_STAGES = 2;
    // sources whose polarity cannot be programmed, and their fixed value
    localparam logic [NUM_SRC-1:0] FIX_MASK = 9'h106;
    localparam logic [NUM_SRC-1:0] FIX_VAL  = 9'h102;
endpackage

// File: rtl/rlic_sync.sv
module rlic_sync #(
    parameter int W = 9,
    parameter int STAGES = 2,
    parameter logic [W-1:0] IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q.stg[i] <= IDLE_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/rlic_polarity.sv
module rlic_polarity #(
    parameter int N = 9,
    parameter logic [N-1:0] FIX_MASK = '0,
    parameter logic [N-1:0] FIX_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wpol,
    input  logic [N-1:0] level,
    output logic [N-1:0] pol,
    output logic [N-1:0] active
);
    typedef struct packed {
        logic [N-1:0] pol;
    } pol_st_t;

    pol_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.pol = (wpol & ~FIX_MASK) | (FIX_VAL & FIX_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.pol <= FIX_VAL & FIX_MASK;
        else        st_q <= st_d;
    end

    assign pol    = st_q.pol;
    assign active = ~(level ^ st_q.pol);
endmodule

// File: rtl/rlic_line.sv
module rlic_line #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wen,
    input  logic [N-1:0] wack,
    input  logic [N-1:0] active,
    output logic [N-1:0] en,
    output logic [N-1:0] pend,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] pend;
    } line_st_t;

    line_st_t   st_d, st_q;
    logic [N-1:0] ack;

    always_comb begin
        st_d = st_q;
        ack  = wr ? wack : '0;
        // a still-active source wins over its own acknowledge
        st_d.pend = (st_q.pend & ~ack) | active;
        if (wr) st_d.en = wen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en   = st_q.en;
    assign pend = st_q.pend;
    assign irq  = |(st_q.pend & st_q.en);
endmodule

// File: rtl/rlic_top.sv
module rlic_top
    import rlic_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int N_LINES = NUM_LINES,
    parameter int DW      = DATA_W,
    parameter int AW      = ADDR_W,
    parameter int PLSB    = PEND_LSB,
    parameter int SYNC_N  = SYNC_STAGES,
    parameter logic [N_SRC-1:0] POL_FIX_MASK = FIX_MASK,
    parameter logic [N_SRC-1:0] POL_FIX_VAL  = FIX_VAL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   irq_in,
    input  logic [AW-1:0]      addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic [N_LINES-1:0] irq_out
);
    localparam int SEL_W = AW - 2;
    localparam logic [N_SRC-1:0] IDLE_LEVEL = ~(POL_FIX_VAL & POL_FIX_MASK);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [SEL_W-1:0]            sel;
    logic [N_SRC-1:0]            level, pol, active;
    logic                        pol_wr;
    logic [N_LINES-1:0]          line_wr;
    logic [N_LINES-1:0][N_SRC-1:0] en_w, pend_w;

    assign sel    = addr[AW-1:2];
    assign pol_wr = wr_en && (sel == '0);

    rlic_sync #(.W(N_SRC), .STAGES(SYNC_N), .IDLE_VAL(IDLE_LEVEL)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(level)
    );

    rlic_polarity #(.N(N_SRC), .FIX_MASK(POL_FIX_MASK), .FIX_VAL(POL_FIX_VAL)) u_pol (
        .clk(clk), .rst_n(rst_n), .wr(pol_wr), .wpol(wdata[N_SRC-1:0]),
        .level(level), .pol(pol), .active(active)
    );

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        assign line_wr[l] = wr_en && (sel == SEL_W'(l + 1));
        rlic_line #(.N(N_SRC)) u_line (
            .clk(clk), .rst_n(rst_n), .wr(line_wr[l]),
            .wen(wdata[N_SRC-1:0]), .wack(wdata[PLSB +: N_SRC]),
            .active(active), .en(en_w[l]), .pend(pend_w[l]), .irq(irq_out[l])
        );
    end

    always_comb begin
        logic [DW-1:0] word;
        word = '0;
        if (sel == '0) begin
            word[N_SRC-1:0] = pol;
        end
        for (int l = 0; l < N_LINES; l++) begin
            if (sel == SEL_W'(l + 1)) begin
                word[N_SRC-1:0]     = en_w[l];
                word[PLSB +: N_SRC] = pend_w[l];
            end
        end
        st_d.rdata = rd_en ? word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.rdata <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/rlic_chk.sv
module rlic_chk #(
    parameter int N_SRC   = 9,
    parameter int N_LINES = 3,
    parameter int DW      = 32,
    parameter int AW      = 4,
    parameter int PLSB    = 16,
    parameter logic [N_SRC-1:0] POL_FIX_MASK = '0,
    parameter logic [N_SRC-1:0] POL_FIX_VAL  = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      addr,
    input logic               wr_en,
    input logic               rd_en,
    input logic [DW-1:0]      wdata,
    input logic [DW-1:0]      rdata,
    input logic [N_LINES-1:0] irq_out
);
    localparam int SEL_W = AW - 2;
    localparam logic [DW-1:0] SRC_ONES  = DW'((64'd1 << N_SRC) - 64'd1);
    localparam logic [DW-1:0] LINE_MASK = SRC_ONES | (SRC_ONES << PLSB);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_out == '0);

    // R8
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rdata == '0);

    // R3
    fixed_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(addr[AW-1:2]) == '0)
        |-> (rdata[N_SRC-1:0] & POL_FIX_MASK) == (POL_FIX_VAL & POL_FIX_MASK));

    // R2
    cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(addr[AW-1:2]) == '0) |-> rdata[DW-1:N_SRC] == '0);

    // R6
    line_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(addr[AW-1:2]) != '0) |-> (rdata & ~LINE_MASK) == '0);

    for (genvar l = 0; l < N_LINES; l++) begin : g_off
        // R9
        line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr[AW-1:2] == SEL_W'(l + 1) && wdata[N_SRC-1:0] == '0)
            |=> !irq_out[l]);
    end
endmodule

bind rlic_top rlic_chk #(
    .N_SRC(N_SRC), .N_LINES(N_LINES), .DW(DW), .AW(AW), .PLSB(PLSB),
    .POL_FIX_MASK(POL_FIX_MASK), .POL_FIX_VAL(POL_FIX_VAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
);

// File: tb/sim_rlic_top.sv
`timescale 1ns/1ps
module sim_rlic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  irq_in = 9'h0FD;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    rlic_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    // behavioural reference
    logic [8:0]  m_sync[$];
    logic [8:0]  m_pol;
    logic [8:0]  m_en[3];
    logic [8:0]  m_pend[3];
    logic [31:0] m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sync = {9'h0FD, 9'h0FD};
            m_pol  = 9'h102;
            foreach (m_en[i]) begin m_en[i] = '0; m_pend[i] = '0; end
            m_rd   = '0;
        end else begin
            logic [8:0]  lvl, act;
            logic [31:0] word;
            int s;
            lvl = m_sync[0];
            act = ~(lvl ^ m_pol);
            s = int'(addr[3:2]);
            word = '0;
            if (s == 0) word[8:0] = m_pol;
            else begin word[8:0] = m_en[s-1]; word[24:16] = m_pend[s-1]; end
            m_rd = rd_en ? word : 32'h0;
            for (int l = 0; l < 3; l++) begin
                logic [8:0] ack;
                ack = (wr_en && s == l + 1) ? wdata[24:16] : 9'h0;
                m_pend[l] = (m_pend[l] & ~ack) | act;
                if (wr_en && s == l + 1) m_en[l] = wdata[8:0];
            end
            if (wr_en && s == 0) m_pol = (wdata[8:0] & ~9'h106) | 9'h102;
            void'(m_sync.pop_front());
            m_sync.push_back(irq_in);
        end
    end

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] exp_irq;
            for (int l = 0; l < 3; l++) exp_irq[l] = |(m_pend[l] & m_en[l]);
            check32({cur_req, " irq_out model"}, {29'h0, irq_out}, {29'h0, exp_irq});
            check32({cur_req, " rdata model"}, rdata, m_rd);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1 addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        @(posedge clk); #1 addr = a; rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0; v = rdata;
    endtask

    task automatic clear_lines();
        wr(4'h4, 32'h01FF0000); wr(4'h8, 32'h01FF0000); wr(4'hC, 32'h01FF0000);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        // R1 reset state
        cyc(3);
        check32("R1 irq_out in reset", {29'h0, irq_out}, 32'h0);
        check32("R1 rdata in reset", rdata, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        rd(4'h0, v); check32("R1 polarity word", v, 32'h00000102);
        rd(4'h4, v); check32("R1 line0", v, 32'h0);
        rd(4'h8, v); check32("R1 line1", v, 32'h0);
        rd(4'hC, v); check32("R1 line2", v, 32'h0);
        // R8 rdata returns to zero
        cyc(1); check32("R8 rdata idle", rdata, 32'h0);

        cur_req = "R2";
        wr(4'h0, 32'h000001FF);
        irq_in = 9'h004;
        rd(4'h0, v); check32("R2 polarity write", v, 32'h000001FB);
        cyc(4); clear_lines(); cyc(2);
        rd(4'h4, v); check32("R2 inverted idle no pending", v, 32'h0);

        cur_req = "R3";
        wr(4'h0, 32'hFFFFFE00);
        irq_in = 9'h0FD;
        rd(4'h0, v); check32("R3 fixed polarity bits", v, 32'h00000102);
        cyc(4); clear_lines(); cyc(2);

        cur_req = "R4";
        wr(4'h8, 32'h00000008);
        @(posedge clk); #1 irq_in = 9'h0F5;
        cyc(1); check32("R4 edge1", {29'h0, irq_out}, 32'h0);
        cyc(1); check32("R4 edge2", {29'h0, irq_out}, 32'h0);
        cyc(1); check32("R7 edge3 line1 raised", {29'h0, irq_out}, 32'h2);
        rd(4'h9, v); check32("R4 line1 word (addr low bits ignored)", v, 32'h00080008);
        rd(4'h4, v); check32("R10 line0 pending without enable", v, 32'h00080000);

        cur_req = "R5";
        irq_in = 9'h0FD; cyc(4);
        wr(4'h8, 32'h00080008);
        check32("R5 ack drops line1", {29'h0, irq_out}, 32'h0);
        rd(4'h8, v); check32("R5 ack clears", v, 32'h00000008);
        rd(4'h4, v); check32("R10 other line kept", v, 32'h00080000);
        wr(4'h4, 32'h0);
        rd(4'h4, v); check32("R5 write zero keeps pending", v, 32'h00080000);
        irq_in = 9'h0F5; cyc(4);
        wr(4'h8, 32'h00080008);
        rd(4'h8, v); check32("R5 ack while active re-sets", v, 32'h00080008);

        cur_req = "R7";
        irq_in = 9'h0FD; cyc(1);
        wr(4'hC, 32'h00000100);
        irq_in = 9'h1FD; cyc(4);
        check32("R7 active-high source on line2", {29'h0, irq_out}, 32'h6);

        cur_req = "R9";
        irq_in = 9'h0FD; cyc(4);
        clear_lines(); cyc(1);
        rd(4'h4, v); check32("R9 line0 cleared", v, 32'h0);
        rd(4'h8, v); check32("R9 line1 cleared", v, 32'h0);
        rd(4'hC, v); check32("R9 line2 cleared", v, 32'h0);
        check32("R9 lines low", {29'h0, irq_out}, 32'h0);

        cur_req = "R6";
        wr(4'hC, 32'hFFFFFFFF);
        rd(4'hC, v); check32("R6 enables and unused bits", v, 32'h000001FF);
        check32("R6 no request without pending", {29'h0, irq_out}, 32'h0);
        wr(4'hC, 32'h01FF0000);
        cyc(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule